// File: doc/BRIEF.md
# Write-Protect Unlock Sequence Detector

This block sits in front of the write engine of a byte-wide nonvolatile memory and holds its software protection state. Byte writes arrive one at a time inside a page-load window, and a separate strobe marks the cycle in which that window closes. While the window is open the block compares the write stream against two fixed key sequences: a three-write arm sequence and a six-write release sequence. Each sequence is an ordered list of address/data pairs set by parameters. When the window closes, the block decides whether the window's payload writes may be committed, and it updates the protection flag.

A completed arm sequence sets protection. It also acts as a one-shot key, so payload writes that follow it in the same window are committed while protection stays set. A completed release sequence clears protection. A window that contains neither sequence is committed only if the block was unprotected when the window began. The protection flag is held in a register that the synchronous reset does not touch, which models a flag that survives loss of power. It comes up unprotected at power-up.

Top module: `wp_unlock_guard`

## Requirements
- R1: After power-up, protect_o is 0, and a window of plain writes closed while unprotected produces commit_ok = 1.
- R2: The arm sequence is three writes in this order: data C3 at address 2A55, then 3C at 15AA, then 96 at 0F0F (hex). When it opens a window, protect_o reads 1 in the cycle after the close strobe.
- R3: The release sequence is six writes in this order: C3@2A55, 3C@15AA, 69@0F0F, A5@3330, 5A@0CC3, E1@1E1E (hex). When it opens a window, protect_o reads 0 in the cycle after the close strobe. If both sequences were ever complete in one window, the release would win.
- R4: While protected, a window without a leading arm or release sequence gives commit_ok = 0, and protect_o stays 1.
- R5: While protected, a window that opens with the arm sequence followed by payload writes gives commit_ok = 1, and protect_o stays 1.
- R6: While unprotected, the arm sequence followed by payload in one window gives commit_ok = 1 and sets protect_o = 1 at the same close.
- R7: Asserting rst leaves protect_o unchanged, clears any partial match and holds commit_ok at 0.
- R8: A write that differs from the next expected key pair abandons that sequence for the rest of the window. The window then follows the protection state that held before it.
- R9: All match progress is discarded when the window closes, so a sequence split across two windows is not recognised.
- R10: commit_ok is a one-cycle pulse in the cycle after the close strobe. It is raised only when the window holds more writes than the completed key sequence used, so a window of key writes alone gives commit_ok = 0.
- R11: A write presented in the same cycle as the close strobe belongs to the window that is closing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not clear protection |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 8 | Data byte of the write |
| win_close | input | 1 | The page-load window closes at this edge |
| protect_o | output | 1 | Current protection state (1 = protected) |
| commit_ok | output | 1 | One-cycle pulse: payload of the closed window may be written |

## Verification
Both outputs are registered, so each result belongs to the clock edge that samples the close strobe and can be read at the falling edge that follows. The bench drives inputs on falling edges. Its behavioural model keeps the window's writes in queues, works out the outcome at that same edge, and is compared with the outputs at every falling edge. Each scenario also makes an explicit check one falling edge after its close strobe, plus one more a cycle later to confirm that commit_ok has dropped.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam int KEY_AW  = 15;
  localparam int KEY_DW  = 8;
  localparam int ARM_LEN = 3;
  localparam int REL_LEN = 6;

  // element 0 is the first write of each sequence
  localparam logic [ARM_LEN-1:0][KEY_AW-1:0] ARM_ADDR_DEF =
    {15'h0F0F, 15'h15AA, 15'h2A55};
  localparam logic [ARM_LEN-1:0][KEY_DW-1:0] ARM_DATA_DEF =
    {8'h96, 8'h3C, 8'hC3};
  localparam logic [REL_LEN-1:0][KEY_AW-1:0] REL_ADDR_DEF =
    {15'h1E1E, 15'h0CC3, 15'h3330, 15'h0F0F, 15'h15AA, 15'h2A55};
  localparam logic [REL_LEN-1:0][KEY_DW-1:0] REL_DATA_DEF =
    {8'hE1, 8'h5A, 8'hA5, 8'h69, 8'h3C, 8'hC3};
endpackage

// File: rtl/wpg_key_matcher.sv
module wpg_key_matcher #(
  parameter int AW = 15,
  parameter int DW = 8,
  parameter int N  = 3,
  parameter logic [N-1:0][AW-1:0] ADDRS = '0,
  parameter logic [N-1:0][DW-1:0] DATAS = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          clear,
  output logic          done_nxt
);
  localparam int IW = $clog2(N + 1);

  logic [IW-1:0] idx_q, idx_d;
  logic          fail_q, fail_d;
  logic [AW-1:0] exp_a;
  logic [DW-1:0] exp_d;

  // select the expected pair for the current position
  always_comb begin
    exp_a = '0;
    exp_d = '0;
    for (int i = 0; i < N; i++) begin
      if (idx_q == IW'(i)) begin
        exp_a = ADDRS[i];
        exp_d = DATAS[i];
      end
    end
  end

  always_comb begin
    idx_d  = idx_q;
    fail_d = fail_q;
    if (wr_valid && !fail_q && (idx_q != IW'(N))) begin
      if ((wr_addr == exp_a) && (wr_data == exp_d)) idx_d = idx_q + 1'b1;
      else                                          fail_d = 1'b1;
    end
  end

  assign done_nxt = (idx_d == IW'(N));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q  <= '0;
      fail_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      fail_q <= fail_d;
    end
  end

  // R8: an abandoned sequence makes no further progress in the window
  a_r8_abort_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !clear) |=> (fail_q && (idx_q == $past(idx_q))));

  // R9: closing the window drops all progress
  a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
    clear |=> ((idx_q == '0) && !fail_q));
endmodule

// File: rtl/wpg_win_counter.sv
module wpg_win_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic          clear,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] cnt_q;

  assign cnt_nxt = (wr_valid && (cnt_q != {CW{1'b1}})) ? cnt_q + 1'b1 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else              cnt_q <= cnt_nxt;
  end

  // R10: the write count never falls inside an open window
  a_r10_count_monotone: assert property (@(posedge clk) disable iff (rst)
    !$past(clear) |-> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/wpg_prot_store.sv
module wpg_prot_store #(
  parameter int CW      = 8,
  parameter int ARM_LEN = 3,
  parameter int REL_LEN = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          close,
  input  logic          arm_done,
  input  logic          rel_done,
  input  logic [CW-1:0] win_cnt,
  output logic          prot,
  output logic          commit
);
  logic          prot_q = 1'b0;   // no reset: models a flag kept across power loss
  logic          commit_q;
  logic [CW-1:0] key_len;
  logic          allow;
  logic          has_payload;

  always_comb begin
    if (rel_done)      key_len = CW'(REL_LEN);
    else if (arm_done) key_len = CW'(ARM_LEN);
    else               key_len = '0;
  end

  assign allow       = !prot_q || arm_done || rel_done;
  assign has_payload = (win_cnt > key_len);

  always_ff @(posedge clk) begin
    if (!rst && close) begin
      if (rel_done)      prot_q <= 1'b0;
      else if (arm_done) prot_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) commit_q <= 1'b0;
    else     commit_q <= close && allow && has_payload;
  end

  assign prot   = prot_q;
  assign commit = commit_q;

  // R2: a completed arm sequence (without release) leaves protection set
  a_r2_arm_sets: assert property (@(posedge clk) disable iff (rst)
    (close && arm_done && !rel_done) |=> prot_q);

  // R3: a completed release sequence clears protection
  a_r3_release_clears: assert property (@(posedge clk) disable iff (rst)
    (close && rel_done) |=> !prot_q);

  // R4: a locked window without a key is never committed
  a_r4_locked_blocks: assert property (@(posedge clk) disable iff (rst)
    (close && prot_q && !arm_done && !rel_done) |=> !commit_q);

  // R7: protection moves only on a window close
  a_r7_prot_needs_close: assert property (@(posedge clk) disable iff (rst)
    !$past(close) |-> $stable(prot_q));

  // R10: commit is a single pulse right after a close
  a_r10_commit_after_close: assert property (@(posedge clk) disable iff (rst)
    commit_q |-> $past(close));
endmodule

// File: rtl/wp_unlock_guard.sv
module wp_unlock_guard
  import wpg_pkg::*;
#(
  parameter int AW    = KEY_AW,
  parameter int DW    = KEY_DW,
  parameter int CNT_W = 8,
  parameter logic [ARM_LEN-1:0][AW-1:0] ARM_ADDR = ARM_ADDR_DEF,
  parameter logic [ARM_LEN-1:0][DW-1:0] ARM_DATA = ARM_DATA_DEF,
  parameter logic [REL_LEN-1:0][AW-1:0] REL_ADDR = REL_ADDR_DEF,
  parameter logic [REL_LEN-1:0][DW-1:0] REL_DATA = REL_DATA_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_close,
  output logic          protect_o,
  output logic          commit_ok
);
  logic             arm_done_nxt;
  logic             rel_done_nxt;
  logic [CNT_W-1:0] cnt_nxt;

  wpg_key_matcher #(
    .AW(AW), .DW(DW), .N(ARM_LEN), .ADDRS(ARM_ADDR), .DATAS(ARM_DATA)
  ) u_arm (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .clear(win_close), .done_nxt(arm_done_nxt)
  );

  wpg_key_matcher #(
    .AW(AW), .DW(DW), .N(REL_LEN), .ADDRS(REL_ADDR), .DATAS(REL_DATA)
  ) u_rel (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .clear(win_close), .done_nxt(rel_done_nxt)
  );

  wpg_win_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .clear(win_close),
    .cnt_nxt(cnt_nxt)
  );

  wpg_prot_store #(.CW(CNT_W), .ARM_LEN(ARM_LEN), .REL_LEN(REL_LEN)) u_store (
    .clk(clk), .rst(rst), .close(win_close), .arm_done(arm_done_nxt),
    .rel_done(rel_done_nxt), .win_cnt(cnt_nxt), .prot(protect_o),
    .commit(commit_ok)
  );

  // R5: an arm key with payload while locked commits and stays locked
  a_r5_unlock_once: assert property (@(posedge clk) disable iff (rst)
    (win_close && protect_o && arm_done_nxt && !rel_done_nxt
     && (cnt_nxt > CNT_W'(ARM_LEN))) |=> (commit_ok && protect_o));
endmodule

// File: tb/tb_wp_unlock_guard.sv
module tb_wp_unlock_guard;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_valid;
  logic [14:0] wr_addr;
  logic [7:0]  wr_data;
  logic        win_close;
  logic        protect_o;
  logic        commit_ok;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  wp_unlock_guard dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_close(win_close), .protect_o(protect_o),
    .commit_ok(commit_ok)
  );

  // key lists as stated in R2 and R3
  logic [14:0] arm_a [3] = '{15'h2A55, 15'h15AA, 15'h0F0F};
  logic [7:0]  arm_d [3] = '{8'hC3, 8'h3C, 8'h96};
  logic [14:0] rel_a [6] = '{15'h2A55, 15'h15AA, 15'h0F0F, 15'h3330, 15'h0CC3, 15'h1E1E};
  logic [7:0]  rel_d [6] = '{8'hC3, 8'h3C, 8'h69, 8'hA5, 8'h5A, 8'hE1};

  // behavioural reference model
  logic [14:0] qa [$];
  logic [7:0]  qd [$];
  bit m_prot   = 1'b0;
  bit m_commit = 1'b0;

  function automatic bit prefix_arm();
    if (qa.size() < 3) return 1'b0;
    for (int i = 0; i < 3; i++)
      if (qa[i] != arm_a[i] || qd[i] != arm_d[i]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic bit prefix_rel();
    if (qa.size() < 6) return 1'b0;
    for (int i = 0; i < 6; i++)
      if (qa[i] != rel_a[i] || qd[i] != rel_d[i]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      qa.delete();
      qd.delete();
      m_commit <= 1'b0;
    end else begin
      bit en, dis, allow;
      int klen;
      if (wr_valid) begin
        qa.push_back(wr_addr);
        qd.push_back(wr_data);
      end
      m_commit <= 1'b0;
      if (win_close) begin
        en    = prefix_arm();
        dis   = prefix_rel();
        klen  = dis ? 6 : (en ? 3 : 0);
        allow = !m_prot || en || dis;
        m_commit <= allow && (qa.size() > klen);
        if (dis)     m_prot <= 1'b0;
        else if (en) m_prot <= 1'b1;
        qa.delete();
        qd.delete();
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (protect_o !== m_prot || commit_ok !== m_commit) begin
      errors++;
      $display("FAIL %s model: protect_o=%b commit_ok=%b expected %b %b",
               cur_req, protect_o, commit_ok, m_prot, m_commit);
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic close_win();
    @(negedge clk);
    win_close = 1'b1;
    @(negedge clk);
    win_close = 1'b0;
  endtask

  task automatic send_arm();
    for (int i = 0; i < 3; i++) wr(arm_a[i], arm_d[i]);
  endtask

  task automatic send_rel(input int upto);
    for (int i = 0; i < upto; i++) wr(rel_a[i], rel_d[i]);
  endtask

  task automatic after_close(input string req, input logic e_prot, input logic e_commit);
    chk(req, "protect_o", protect_o, e_prot);
    chk(req, "commit_ok", commit_ok, e_commit);
    @(negedge clk);
    chk("R10", "commit_ok pulse ends", commit_ok, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_valid = 1'b0; wr_addr = '0; wr_data = '0; win_close = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "protect_o at power-up", protect_o, 1'b0);
    chk("R7", "commit_ok in reset", commit_ok, 1'b0);
    rst = 1'b0;

    cur_req = "R1";
    wr(15'h0100, 8'h11); wr(15'h0101, 8'h22); close_win();
    after_close("R1", 1'b0, 1'b1);

    cur_req = "R2";
    send_arm(); close_win();
    after_close("R2", 1'b1, 1'b0);   // key only: R10 no commit

    cur_req = "R4";
    wr(15'h0200, 8'h33); close_win();
    after_close("R4", 1'b1, 1'b0);

    cur_req = "R7";
    @(negedge clk); rst = 1'b1;
    wr(arm_a[0], arm_d[0]);
    repeat (2) @(negedge clk); rst = 1'b0;
    chk("R7", "protect_o kept over reset", protect_o, 1'b1);
    wr(arm_a[1], arm_d[1]); wr(arm_a[2], arm_d[2]); wr(15'h0300, 8'h44); close_win();
    after_close("R7", 1'b1, 1'b0);   // match from before reset was dropped

    cur_req = "R5";
    send_arm(); wr(15'h0400, 8'h55); wr(15'h0401, 8'h66); close_win();
    after_close("R5", 1'b1, 1'b1);

    cur_req = "R8";
    wr(arm_a[0], arm_d[0]); wr(arm_a[1], 8'h00); wr(arm_a[2], arm_d[2]);
    wr(15'h0500, 8'h77); close_win();
    after_close("R8", 1'b1, 1'b0);

    cur_req = "R9";
    wr(arm_a[0], arm_d[0]); wr(arm_a[1], arm_d[1]); close_win();
    after_close("R9", 1'b1, 1'b0);
    wr(arm_a[2], arm_d[2]); wr(15'h0600, 8'h88); close_win();
    after_close("R9", 1'b1, 1'b0);

    cur_req = "R3";
    send_rel(6); close_win();
    after_close("R3", 1'b0, 1'b0);

    cur_req = "R8";
    send_rel(3); wr(15'h0700, 8'h99); wr(rel_a[4], rel_d[4]); close_win();
    after_close("R8", 1'b0, 1'b1);   // aborted release, unprotected rules

    cur_req = "R6";
    send_arm(); wr(15'h0800, 8'hAA); close_win();
    after_close("R6", 1'b1, 1'b1);

    cur_req = "R11";
    send_rel(5);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = rel_a[5]; wr_data = rel_d[5]; win_close = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; win_close = 1'b0;
    after_close("R11", 1'b0, 1'b0);

    cur_req = "R11";
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 15'h0900; wr_data = 8'hBB; win_close = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; win_close = 1'b0;
    after_close("R11", 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule